// File: doc/BRIEF.md
# Alarm-Driven Power Rail Controller

This block drives the enable pin of an external power regulator and turns the rail off when a second alarm fires. A calendar comparator elsewhere produces a one-cycle match pulse. If a level input enables that alarm and software has handed the rail to this block through a 32-bit control word, the rail enable falls on the next clock edge. It then stays low until reset, until software takes the pin back, or until one of four external wake inputs reaches its active level.

Each wake input has its own enable bit and its own polarity bit in the control word. The block passes every input through a two-flop synchronizer before it qualifies it. The OR of the qualified inputs is the wake event, and a wake event turns the rail back on. Every match that is enabled also sets a sticky alarm flag. Software clears that flag by pulsing a clear input, the same effect as a write-one-to-clear.

Top module: `pmic_power_ctrl`

## Requirements
- R1: A control write stores bit 16 (rail ownership), bits 3:0 (wake enables for inputs 3..0) and bits 7:4 (wake polarities for inputs 3..0). All other bits read back as 0 on `ctrl_q` from the cycle after the write.
- R2: Reset clears the control word and the alarm flag, drives `pwr_en` high (rail on) and holds `wake_evt` low.
- R3: While bit 16 is 0, `pwr_en` stays 1 whatever the alarm inputs do.
- R4: When `alm2_match` and `alm2_en` are both 1 while bit 16 is 1, `pwr_en` is 0 from the next clock edge.
- R5: A match pulse while `alm2_en` is 0 is ignored: `pwr_en` stays 1 and the flag stays 0.
- R6: Once the rail is off, it stays off until a wake event, a reset or a write that clears bit 16. Clearing bit 16 restores `pwr_en` to 1 in the cycle after the write.
- R7: Input i is active when enable bit i is 1 and its level matches polarity bit 4+i (polarity 1 = active-low, 0 = active-high). `wake_evt` reflects a pin change after two clock edges.
- R8: An input whose enable bit is 0 never raises `wake_evt`.
- R9: A wake event while the rail is off restores `pwr_en` to 1 at the next edge. If an enabled alarm match arrives in the same cycle, the alarm wins and the rail goes or stays off.
- R10: `alm2_flag` is set by a match while `alm2_en` is 1, whether or not bit 16 is 1. It holds until a pulse on `alm2_clr`. If a set and a clear arrive together, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write data |
| ctrl_q | output | 32 | Stored control word |
| alm2_match | input | 1 | One-cycle second-alarm match pulse |
| alm2_en | input | 1 | Second-alarm enable level |
| alm2_clr | input | 1 | Clear pulse for the alarm flag |
| wake_pins | input | 4 | Asynchronous external wake inputs |
| pwr_en | output | 1 | Power rail enable (1 = on) |
| wake_evt | output | 1 | Qualified wake event |
| alm2_flag | output | 1 | Sticky second-alarm flag |

## Verification
The bench targets the cycle where an alarm match and a wake event collide. A design that gives the wake event priority there would leave the rail on when it should switch off. Pin changes are timed against the synchronizer so that an off-by-one stage count, or an inverted polarity convention, shows up as `wake_evt` in the wrong cycle. Clearing ownership while the rail is off catches a design that keeps the rail dark after software has taken the pin back. A simultaneous flag set and clear catches a design that lets the clear win.

// File: rtl/pmic_pkg.sv
package pmic_pkg;

  // Polarity 1 means active-low, 0 means active-high.
  function automatic logic wake_hit(input logic en, input logic pol, input logic lvl);
    return en & (lvl ^ pol);
  endfunction

  // Bits the control word keeps: ownership bit plus enables and polarities.
  function automatic logic [31:0] ctrl_keep_mask(input int num_wake, input int own_bit);
    logic [31:0] m;
    m = '0;
    m[own_bit] = 1'b1;
    for (int i = 0; i < 2 * num_wake; i++) m[i] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/pmic_wake_sync.sv
module pmic_wake_sync #(
  parameter int NUM_WAKE    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_WAKE-1:0] pins,
  input  logic [NUM_WAKE-1:0] en,
  input  logic [NUM_WAKE-1:0] pol,
  output logic                wake_evt
);
  import pmic_pkg::*;

  logic [NUM_WAKE-1:0] pin_sync;
  logic [NUM_WAKE-1:0] hit;

  for (genvar g = 0; g < NUM_WAKE; g++) begin : g_in
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[SYNC_STAGES-2:0], pins[g]};
    end
    assign pin_sync[g] = chain[SYNC_STAGES-1];
    assign hit[g]      = wake_hit(en[g], pol[g], pin_sync[g]);
  end

  assign wake_evt = |hit;

  AST_WAKE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |-> (|en)); // R8

endmodule

// File: rtl/pmic_rail_ctrl.sv
module pmic_rail_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic own,
  input  logic alm_match,
  input  logic alm_en,
  input  logic flag_clr,
  input  logic wake_evt,
  output logic trig,
  output logic pwr_en,
  output logic flag
);

  logic alm_hit;
  logic off_q;

  assign alm_hit = alm_match & alm_en;
  assign trig    = alm_hit & own;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        off_q <= 1'b0;
    else if (!own)     off_q <= 1'b0;
    else if (trig)     off_q <= 1'b1;
    else if (wake_evt) off_q <= 1'b0;
  end

  assign pwr_en = ~(off_q & own);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (alm_hit)  flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    alm_hit |=> flag); // R10
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !alm_hit) |=> !flag); // R10
  AST_WAKE_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_en && wake_evt && !trig) |=> pwr_en); // R9

endmodule

// File: rtl/pmic_power_ctrl.sv
module pmic_power_ctrl #(
  parameter int NUM_WAKE    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int CTRL_W      = 32,
  parameter int OWN_BIT     = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctrl_we,
  input  logic [CTRL_W-1:0]   ctrl_wdata,
  output logic [CTRL_W-1:0]   ctrl_q,
  input  logic                alm2_match,
  input  logic                alm2_en,
  input  logic                alm2_clr,
  input  logic [NUM_WAKE-1:0] wake_pins,
  output logic                pwr_en,
  output logic                wake_evt,
  output logic                alm2_flag
);
  import pmic_pkg::*;

  localparam int POL_LSB = NUM_WAKE;
  localparam logic [31:0] KEEP = ctrl_keep_mask(NUM_WAKE, OWN_BIT);

  logic [CTRL_W-1:0] ctrl_r;
  logic              trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_r <= '0;
    else if (ctrl_we) ctrl_r <= ctrl_wdata & KEEP[CTRL_W-1:0];
  end
  assign ctrl_q = ctrl_r;

  pmic_wake_sync #(.NUM_WAKE(NUM_WAKE), .SYNC_STAGES(SYNC_STAGES)) u_wake (
    .clk      (clk),
    .rst_n    (rst_n),
    .pins     (wake_pins),
    .en       (ctrl_r[NUM_WAKE-1:0]),
    .pol      (ctrl_r[POL_LSB +: NUM_WAKE]),
    .wake_evt (wake_evt)
  );

  pmic_rail_ctrl u_rail (
    .clk       (clk),
    .rst_n     (rst_n),
    .own       (ctrl_r[OWN_BIT]),
    .alm_match (alm2_match),
    .alm_en    (alm2_en),
    .flag_clr  (alm2_clr),
    .wake_evt  (wake_evt),
    .trig      (trig),
    .pwr_en    (pwr_en),
    .flag      (alm2_flag)
  );

  AST_ALARM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !ctrl_we) |=> !pwr_en); // R4
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_en && !wake_evt && !ctrl_we) |=> !pwr_en); // R6
  AST_NOT_OWNED_ON: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[OWN_BIT] |-> pwr_en); // R3
  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (ctrl_q == ($past(ctrl_wdata) & KEEP[CTRL_W-1:0]))); // R1

endmodule

// File: tb/tb_pmic_power_ctrl.sv
module tb_pmic_power_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic [31:0] ctrl_q;
  logic        alm2_match = 1'b0;
  logic        alm2_en = 1'b0;
  logic        alm2_clr = 1'b0;
  logic [3:0]  wake_pins = '0;
  logic        pwr_en, wake_evt, alm2_flag;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pmic_power_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_q(ctrl_q), .alm2_match(alm2_match), .alm2_en(alm2_en),
    .alm2_clr(alm2_clr), .wake_pins(wake_pins), .pwr_en(pwr_en),
    .wake_evt(wake_evt), .alm2_flag(alm2_flag)
  );

  // Behavioural reference model
  logic [31:0] m_ctrl;
  logic [3:0]  m_hist[$];
  bit          m_off, m_flag;

  function automatic bit model_wake();
    bit any = 0;
    for (int i = 0; i < 4; i++)
      if (m_ctrl[i] && (m_hist[0][i] == !m_ctrl[4+i])) any = 1;
    return any;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_off = 0; m_flag = 0;
      m_hist = {4'b0000, 4'b0000};
    end else begin
      bit hit, w;
      hit = alm2_match && alm2_en;
      w = model_wake();
      if (!m_ctrl[16])     m_off = 0;
      else if (hit)        m_off = 1;
      else if (w)          m_off = 0;
      if (hit)             m_flag = 1;
      else if (alm2_clr)   m_flag = 0;
      if (ctrl_we) m_ctrl = ctrl_wdata & 32'h0001_00FF;
      m_hist.push_back(wake_pins);
      void'(m_hist.pop_front());
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 ctrl_q model", ctrl_q, m_ctrl);
      chk("R4 pwr_en model", {31'b0, pwr_en}, {31'b0, !(m_off && m_ctrl[16])});
      chk("R7 wake_evt model", {31'b0, wake_evt}, {31'b0, model_wake()});
      chk("R10 alm2_flag model", {31'b0, alm2_flag}, {31'b0, m_flag});
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [31:0] v);
    ctrl_we = 1; ctrl_wdata = v; tick(); ctrl_we = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    done = 1;
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R2 ctrl reset", ctrl_q, 0);
    chk("R2 pwr reset", {31'b0, pwr_en}, 1);
    chk("R2 wake reset", {31'b0, wake_evt}, 0);
    chk("R2 flag reset", {31'b0, alm2_flag}, 0);

    wr(32'hFFFF_FFFF);
    chk("R1 masked write", ctrl_q, 32'h0001_00FF);
    wr(32'h0001_0000);

    alm2_match = 1; alm2_en = 0; tick(); alm2_match = 0;
    chk("R5 pwr ignored", {31'b0, pwr_en}, 1);
    chk("R5 flag ignored", {31'b0, alm2_flag}, 0);

    alm2_match = 1; alm2_en = 1; tick(); alm2_match = 0;
    chk("R4 rail off", {31'b0, pwr_en}, 0);
    chk("R10 flag set", {31'b0, alm2_flag}, 1);
    repeat (5) tick();
    chk("R6 stays off", {31'b0, pwr_en}, 0);
    alm2_clr = 1; tick(); alm2_clr = 0;
    chk("R10 flag cleared", {31'b0, alm2_flag}, 0);
    alm2_match = 1; alm2_clr = 1; tick(); alm2_match = 0; alm2_clr = 0;
    chk("R10 set beats clear", {31'b0, alm2_flag}, 1);

    wr(32'h0001_0001);
    chk("R7 inactive pin", {31'b0, wake_evt}, 0);
    wake_pins = 4'b0001; tick();
    chk("R7 one stage only", {31'b0, wake_evt}, 0);
    tick();
    chk("R7 high-active wake", {31'b0, wake_evt}, 1);
    chk("R9 still off", {31'b0, pwr_en}, 0);
    tick();
    chk("R9 wake restores", {31'b0, pwr_en}, 1);
    wake_pins = 4'b1110; repeat (3) tick();
    chk("R8 disabled inputs", {31'b0, wake_evt}, 0);

    wr(32'h0001_0022); tick();
    chk("R7 low-active idle", {31'b0, wake_evt}, 0);
    wake_pins = 4'b1100; tick(); tick();
    chk("R7 low-active wake", {31'b0, wake_evt}, 1);

    wr(32'h0000_0000); wake_pins = 4'b0000;
    alm2_match = 1; tick(); alm2_match = 0;
    chk("R3 unowned stays on", {31'b0, pwr_en}, 1);
    tick();
    chk("R3 unowned later", {31'b0, pwr_en}, 1);

    wr(32'h0001_0001); wake_pins = 4'b0001; repeat (3) tick();
    alm2_match = 1; tick(); alm2_match = 0;
    chk("R9 alarm beats wake", {31'b0, pwr_en}, 0);
    tick();
    chk("R9 wake after alarm", {31'b0, pwr_en}, 1);

    wake_pins = 4'b0000; repeat (3) tick();
    alm2_match = 1; tick(); alm2_match = 0;
    chk("R6 off before release", {31'b0, pwr_en}, 0);
    wr(32'h0000_0000);
    chk("R6 release by owner clear", {31'b0, pwr_en}, 1);

    for (int n = 0; n < 3000; n++) begin
      alm2_match = ($urandom_range(0, 11) == 0);
      alm2_en    = ($urandom_range(0, 3) != 0);
      alm2_clr   = ($urandom_range(0, 15) == 0);
      ctrl_we    = ($urandom_range(0, 31) == 0);
      ctrl_wdata = $urandom();
      if ($urandom_range(0, 7) == 0) wake_pins = 4'($urandom());
      tick();
    end
    ctrl_we = 0; alm2_match = 0; alm2_clr = 0;

    rst_n = 0; tick(); rst_n = 1;
    chk("R2 ctrl after reset", ctrl_q, 0);
    chk("R2 pwr after reset", {31'b0, pwr_en}, 1);
    chk("R2 flag after reset", {31'b0, alm2_flag}, 0);
    done = 1;
    summary();
  end

endmodule